// File: doc/BRIEF.md
# Source-Routed Path Header Processor

This block handles path headers for a two-dimensional mesh that routes from the source. Every hop of a packet's path is decided when the packet is injected. The injecting node keeps a small table with up to two precomputed routes for each destination. A route is a string of 3-bit direction symbols that ends in an exit symbol. When a packet is injected, the block looks up its destination and picks one of the stored routes. A per-destination toggle makes consecutive packets to the same destination alternate between the two routes. This spreads the load, and it lets a faulty path be avoided by rewriting or invalidating one of the routes.

At every router the block reads the leading symbol of the header route field. It reports that symbol as the output port and passes on the field shifted left by one symbol, with an exit symbol filled in at the bottom. When the leading symbol is the exit symbol, the packet leaves the network at this router. Routers compute nothing more than this, so the cost of each hop stays fixed. The cost of the scheme is in table storage and in header bits.

Symbol encoding: north 0, east 1, south 2, west 3, exit 4. Codes 5 to 7 are illegal. The route field holds 8 symbols, and symbol 0 sits in bits [23:21]. Software can rewrite the table at run time. A write is checked before it is stored.

Top module: `src_route_hdr`

## Requirements
- R1: After reset, every destination's first route is all exit symbols and its second route is invalid. Injecting to any destination then returns an all-exit route with `inj_alt_o`=0, and `inj_valid_o`, `hop_valid_o` and `tw_rej_o` are all 0.
- R2: An accepted write with `tw_slot_i`=0 stores the first route, and one with `tw_slot_i`=1 stores the second route and marks it valid. An injection issued on a later cycle returns the stored route one cycle after `inj_valid_i`. A route with 7 directions followed by an exit symbol is accepted.
- R3: While the second route is valid, consecutive injections to the same destination alternate between the routes, starting with route 1 after reset. `inj_alt_o`=1 marks route 2.
- R4: While the second route is invalid, every injection returns route 1 with `inj_alt_o`=0.
- R5: Each destination has its own alternation state, so injections to other destinations in between do not change the sequence a destination sees.
- R6: A written route with no exit symbol among its 8 symbols is rejected. `tw_rej_o` is 1 in the cycle after the write, and the table entry keeps its old value.
- R7: A written route that holds a code from 5 to 7, or a non-exit symbol after an exit symbol, is rejected in the same way as R6.
- R8: One cycle after `hop_valid_i`, `hop_valid_o`=1, `hop_port_o` equals symbol 0 of `hop_route_i`, and `hop_route_o` is the input field shifted left by 3 bits with exit (4) filled into the lowest symbol.
- R9: `hop_eject_o`=1 exactly when the symbol taken by a hop is the exit symbol.
- R10: A write with `tw_clr_i`=1 invalidates the destination's second route, whatever `tw_slot_i` and `tw_route_i` hold. It is never rejected.
- R11: Rewriting a route that already holds a value replaces it, and the new route takes effect for later injections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tw_en_i | input | 1 | Table write strobe |
| tw_clr_i | input | 1 | With the strobe: invalidate the second route |
| tw_dest_i | input | 4 | Destination written |
| tw_slot_i | input | 1 | 0 selects route 1, 1 selects route 2 |
| tw_route_i | input | 24 | Route written, symbol 0 in the top bits |
| tw_rej_o | output | 1 | Previous cycle's write was rejected |
| inj_valid_i | input | 1 | Injection lookup request |
| inj_dest_i | input | 4 | Destination of the injected packet |
| inj_valid_o | output | 1 | Lookup result valid |
| inj_route_o | output | 24 | Selected route for the header |
| inj_alt_o | output | 1 | 1 if route 2 was selected |
| hop_valid_i | input | 1 | Header present at this hop |
| hop_route_i | input | 24 | Incoming header route field |
| hop_valid_o | output | 1 | Hop result valid |
| hop_port_o | output | 3 | Selected output port symbol |
| hop_route_o | output | 24 | Shifted route field for the next hop |
| hop_eject_o | output | 1 | Packet leaves at this hop |

## Verification
A corrupted table entry or second-route valid bit appears at the ports on the next injection to that destination, one cycle after the request, as a wrong route or a wrong `inj_alt_o`. A toggle bit that flips wrongly or fails to flip gives an out-of-order alternation, and that shows up within two injections to the same destination. A wrong shift or fill in the hop stage shows up on the first hop. Walking a route to its end brings out a wrong fill as a missed or early eject.

// File: rtl/srcrt_pkg.sv
package srcrt_pkg;
  localparam int SYM_W = 3;
  typedef enum logic [SYM_W-1:0] {
    DIR_N    = 3'd0,
    DIR_E    = 3'd1,
    DIR_S    = 3'd2,
    DIR_W    = 3'd3,
    DIR_EXIT = 3'd4
  } dir_e;
endpackage

// File: rtl/srcrt_route_check.sv
module srcrt_route_check
  import srcrt_pkg::*;
#(
  parameter int MAX_HOPS = 8,
  localparam int RTE_W = MAX_HOPS * SYM_W
) (
  input  logic [RTE_W-1:0] route_i,
  output logic             ok_o
);
  logic [MAX_HOPS-1:0] is_dir, is_x;

  for (genvar g = 0; g < MAX_HOPS; g++) begin : g_sym
    logic [SYM_W-1:0] sym;
    assign sym       = route_i[RTE_W-1-g*SYM_W -: SYM_W];
    assign is_dir[g] = (sym < SYM_W'(DIR_EXIT));
    assign is_x[g]   = (sym == SYM_W'(DIR_EXIT));
  end

  // canonical: directions, then one exit, then exit padding only
  always_comb begin
    logic seen, bad;
    seen = 1'b0;
    bad  = 1'b0;
    for (int i = 0; i < MAX_HOPS; i++) begin
      if (!is_x[i] && !is_dir[i]) bad = 1'b1;
      if (seen && !is_x[i])       bad = 1'b1;
      if (is_x[i])                seen = 1'b1;
    end
    ok_o = seen && !bad;
  end
endmodule

// File: rtl/srcrt_route_table.sv
module srcrt_route_table
  import srcrt_pkg::*;
#(
  parameter int NUM_DEST = 16,
  parameter int MAX_HOPS = 8,
  localparam int DEST_W = $clog2(NUM_DEST),
  localparam int RTE_W  = MAX_HOPS * SYM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              clr_en_i,
  input  logic [DEST_W-1:0] wr_dest_i,
  input  logic              wr_slot_i,
  input  logic [RTE_W-1:0]  wr_route_i,
  input  logic              lk_en_i,
  input  logic [DEST_W-1:0] lk_dest_i,
  output logic              lk_vld_o,
  output logic [RTE_W-1:0]  lk_route_o,
  output logic              lk_alt_o
);
  localparam logic [RTE_W-1:0] ALL_EXIT = {MAX_HOPS{SYM_W'(DIR_EXIT)}};

  logic [NUM_DEST-1:0][RTE_W-1:0] r1_q, r2_q;
  logic [NUM_DEST-1:0]            v2_q, tog_q;
  logic                           use2;

  assign use2 = v2_q[lk_dest_i] & tog_q[lk_dest_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r1_q <= {NUM_DEST{ALL_EXIT}};
      r2_q <= {NUM_DEST{ALL_EXIT}};
    end else if (wr_en_i) begin
      if (wr_slot_i) r2_q[wr_dest_i] <= wr_route_i;
      else           r1_q[wr_dest_i] <= wr_route_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q <= '0;
    end else if (clr_en_i) begin
      v2_q[wr_dest_i] <= 1'b0;
    end else if (wr_en_i && wr_slot_i) begin
      v2_q[wr_dest_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= '0;
    end else if (lk_en_i && v2_q[lk_dest_i]) begin
      tog_q[lk_dest_i] <= ~tog_q[lk_dest_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_vld_o   <= 1'b0;
      lk_route_o <= ALL_EXIT;
      lk_alt_o   <= 1'b0;
    end else begin
      lk_vld_o <= lk_en_i;
      if (lk_en_i) begin
        lk_route_o <= use2 ? r2_q[lk_dest_i] : r1_q[lk_dest_i];
        lk_alt_o   <= use2;
      end
    end
  end

  AST_ALT_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_en_i && v2_q[lk_dest_i] |=> tog_q[$past(lk_dest_i)] != $past(tog_q[lk_dest_i])); // R3
  AST_ALT_NO_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_en_i && !v2_q[lk_dest_i] |=> lk_vld_o && !lk_alt_o); // R4
  AST_TABLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(r1_q) && $stable(r2_q)); // R6
endmodule

// File: rtl/srcrt_hop_stage.sv
module srcrt_hop_stage
  import srcrt_pkg::*;
#(
  parameter int MAX_HOPS = 8,
  localparam int RTE_W = MAX_HOPS * SYM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [RTE_W-1:0] route_i,
  output logic             valid_o,
  output logic [SYM_W-1:0] port_o,
  output logic [RTE_W-1:0] route_o,
  output logic             eject_o
);
  logic [SYM_W-1:0] head;
  assign head = route_i[RTE_W-1 -: SYM_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      port_o  <= SYM_W'(DIR_EXIT);
      route_o <= {MAX_HOPS{SYM_W'(DIR_EXIT)}};
      eject_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        port_o  <= head;
        route_o <= {route_i[RTE_W-SYM_W-1:0], SYM_W'(DIR_EXIT)};
        eject_o <= (head == SYM_W'(DIR_EXIT));
      end
    end
  end

  AST_HOP_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o && port_o == $past(route_i[RTE_W-1 -: SYM_W])); // R8
  AST_HOP_EJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && route_i[RTE_W-1 -: SYM_W] == SYM_W'(DIR_EXIT) |=> eject_o); // R9
endmodule

// File: rtl/src_route_hdr.sv
module src_route_hdr
  import srcrt_pkg::*;
#(
  parameter int NUM_DEST = 16,
  parameter int MAX_HOPS = 8,
  localparam int DEST_W = $clog2(NUM_DEST),
  localparam int RTE_W  = MAX_HOPS * SYM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tw_en_i,
  input  logic              tw_clr_i,
  input  logic [DEST_W-1:0] tw_dest_i,
  input  logic              tw_slot_i,
  input  logic [RTE_W-1:0]  tw_route_i,
  output logic              tw_rej_o,
  input  logic              inj_valid_i,
  input  logic [DEST_W-1:0] inj_dest_i,
  output logic              inj_valid_o,
  output logic [RTE_W-1:0]  inj_route_o,
  output logic              inj_alt_o,
  input  logic              hop_valid_i,
  input  logic [RTE_W-1:0]  hop_route_i,
  output logic              hop_valid_o,
  output logic [SYM_W-1:0]  hop_port_o,
  output logic [RTE_W-1:0]  hop_route_o,
  output logic              hop_eject_o
);
  logic route_ok, wr_acc, clr_acc, wr_bad;

  srcrt_route_check #(.MAX_HOPS(MAX_HOPS)) u_check (
    .route_i (tw_route_i),
    .ok_o    (route_ok)
  );

  assign clr_acc = tw_en_i && tw_clr_i;
  assign wr_acc  = tw_en_i && !tw_clr_i && route_ok;
  assign wr_bad  = tw_en_i && !tw_clr_i && !route_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tw_rej_o <= 1'b0;
    else         tw_rej_o <= wr_bad;
  end

  srcrt_route_table #(.NUM_DEST(NUM_DEST), .MAX_HOPS(MAX_HOPS)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_acc),
    .clr_en_i   (clr_acc),
    .wr_dest_i  (tw_dest_i),
    .wr_slot_i  (tw_slot_i),
    .wr_route_i (tw_route_i),
    .lk_en_i    (inj_valid_i),
    .lk_dest_i  (inj_dest_i),
    .lk_vld_o   (inj_valid_o),
    .lk_route_o (inj_route_o),
    .lk_alt_o   (inj_alt_o)
  );

  srcrt_hop_stage #(.MAX_HOPS(MAX_HOPS)) u_hop (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (hop_valid_i),
    .route_i (hop_route_i),
    .valid_o (hop_valid_o),
    .port_o  (hop_port_o),
    .route_o (hop_route_o),
    .eject_o (hop_eject_o)
  );

  AST_REJ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tw_rej_o |-> $past(tw_en_i) && !$past(tw_clr_i)); // R6
  AST_CLR_NEVER_REJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tw_en_i && tw_clr_i |=> !tw_rej_o); // R10
endmodule

// File: tb/sim_src_route_hdr.sv
module sim_src_route_hdr;
  localparam int ND = 16;
  localparam int RW = 24;
  localparam logic [RW-1:0] AX = {8{3'd4}};

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic tw_en = 0, tw_clr = 0, tw_slot = 0, tw_rej;
  logic [3:0] tw_dest = 0, inj_dest = 0;
  logic [RW-1:0] tw_route = AX, inj_route, hop_route_i = AX, hop_route_o;
  logic inj_v = 0, inj_vo, inj_alt, hop_v = 0, hop_vo, hop_ej;
  logic [2:0] hop_port;

  src_route_hdr u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tw_en_i(tw_en), .tw_clr_i(tw_clr), .tw_dest_i(tw_dest), .tw_slot_i(tw_slot),
    .tw_route_i(tw_route), .tw_rej_o(tw_rej),
    .inj_valid_i(inj_v), .inj_dest_i(inj_dest), .inj_valid_o(inj_vo),
    .inj_route_o(inj_route), .inj_alt_o(inj_alt),
    .hop_valid_i(hop_v), .hop_route_i(hop_route_i), .hop_valid_o(hop_vo),
    .hop_port_o(hop_port), .hop_route_o(hop_route_o), .hop_eject_o(hop_ej)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // model of the table, from the requirements
  logic [RW-1:0] m_r1 [ND];
  logic [RW-1:0] m_r2 [ND];
  bit m_v2 [ND];
  bit m_tog [ND];

  // scoreboard queues: {tag, route, flag}
  logic [RW:0]   q_inj [$];
  logic [RW+3:0] q_hop [$];
  string         t_inj [$];
  string         t_hop [$];

  function automatic logic [RW-1:0] rt(string s);
    logic [RW-1:0] r = AX;
    logic [2:0] c;
    for (int i = 0; i < s.len() && i < 8; i++) begin
      case (s[i])
        "N": c = 3'd0;
        "E": c = 3'd1;
        "S": c = 3'd2;
        "W": c = 3'd3;
        default: c = 3'd4;
      endcase
      r[RW-1-3*i -: 3] = c;
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] d, bit slot, logic [RW-1:0] r, bit exp_rej, string req);
    @(negedge clk);
    tw_en = 1; tw_clr = 0; tw_dest = d; tw_slot = slot; tw_route = r;
    @(negedge clk);
    tw_en = 0;
    chk(tw_rej == exp_rej, req, 32'(tw_rej), 32'(exp_rej));
    if (!exp_rej) begin
      if (slot) begin m_r2[d] = r; m_v2[d] = 1; end
      else m_r1[d] = r;
    end
  endtask

  task automatic clr(logic [3:0] d);
    @(negedge clk);
    tw_en = 1; tw_clr = 1; tw_dest = d; tw_slot = 0; tw_route = 24'hFFFFFF;
    @(negedge clk);
    tw_en = 0; tw_clr = 0;
    chk(tw_rej == 0, "R10 clear not rejected", 32'(tw_rej), 0);
    m_v2[d] = 0;
  endtask

  task automatic inj(logic [3:0] d, string req);
    bit use2;
    @(negedge clk);
    inj_v = 1; inj_dest = d;
    use2 = m_v2[d] && m_tog[d];
    q_inj.push_back({use2 ? m_r2[d] : m_r1[d], use2});
    t_inj.push_back(req);
    if (m_v2[d]) m_tog[d] = !m_tog[d];
    @(negedge clk);
    inj_v = 0;
  endtask

  // walk a route string hop by hop, feeding the design's output back
  task automatic walk(string s, string req);
    logic [RW-1:0] cur = rt(s);
    for (int i = 0; i < s.len(); i++) begin
      logic [2:0] p;
      p = rt(s.substr(i, i))[RW-1 -: 3];
      @(negedge clk);
      hop_v = 1; hop_route_i = cur;
      q_hop.push_back({p, rt(s.substr(i + 1, s.len() - 1)), s[i] == "X"});
      t_hop.push_back(req);
      @(negedge clk);
      hop_v = 0;
      cur = hop_route_o;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (inj_vo) begin
        if (q_inj.size() == 0) chk(0, "R2 unexpected inj", 1, 0);
        else begin
          logic [RW:0] e;
          string tg;
          e = q_inj.pop_front(); tg = t_inj.pop_front();
          chk({inj_route, inj_alt} == e, tg, 32'({inj_route, inj_alt}), 32'(e));
        end
      end
      if (hop_vo) begin
        if (q_hop.size() == 0) chk(0, "R8 unexpected hop", 1, 0);
        else begin
          logic [RW+3:0] e;
          string tg;
          e = q_hop.pop_front(); tg = t_hop.pop_front();
          chk({hop_port, hop_route_o, hop_ej} == e, tg,
              32'({hop_port, hop_route_o, hop_ej}), 32'(e));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ND; i++) begin
      m_r1[i] = AX; m_r2[i] = AX; m_v2[i] = 0; m_tog[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(inj_vo == 0 && hop_vo == 0 && tw_rej == 0, "R1 reset outputs",
        32'({inj_vo, hop_vo, tw_rej}), 0);
    inj(4'd3, "R1 reset route all exit");
    inj(4'd3, "R1 reset route repeat");

    wr(4'd5, 0, rt("NEEX"), 0, "R2 write r1");
    wr(4'd5, 1, rt("ENEX"), 0, "R2 write r2");
    inj(4'd5, "R3 first r1");
    inj(4'd5, "R3 second r2");
    inj(4'd5, "R3 third r1");

    wr(4'd6, 0, rt("SX"), 0, "R4 write r1 only");
    inj(4'd6, "R4 r1 only a");
    inj(4'd6, "R4 r1 only b");

    wr(4'd7, 0, rt("WX"), 0, "R5 write d7 r1");
    wr(4'd7, 1, rt("SWX"), 0, "R5 write d7 r2");
    inj(4'd7, "R5 d7 first");
    inj(4'd5, "R5 d5 continues");
    inj(4'd7, "R5 d7 second");
    inj(4'd5, "R5 d5 again");

    wr(4'd5, 0, rt("NNNNEEEE"), 1, "R6 no exit rejected");
    wr(4'd5, 0, {3'd6, rt("X")[RW-4:0]}, 1, "R7 bad code rejected");
    wr(4'd5, 0, rt("NXE"), 1, "R7 symbol after exit rejected");
    inj(4'd5, "R6 entry unchanged a");
    inj(4'd5, "R6 entry unchanged b");

    wr(4'd9, 1, rt("NNNEEEEX"), 0, "R2 longest route accepted");
    inj(4'd9, "R2 d9 r1");
    inj(4'd9, "R2 d9 longest r2");

    clr(4'd5);
    inj(4'd5, "R10 after clear a");
    inj(4'd5, "R10 after clear b");

    wr(4'd5, 0, rt("SSX"), 0, "R11 rewrite r1");
    inj(4'd5, "R11 new route used");

    walk("NEEX", "R8 walk NEEX");
    walk("ESWNNWSX", "R8 walk full length");
    walk("X", "R9 eject at once");

    // back-to-back hops
    @(negedge clk);
    hop_v = 1; hop_route_i = rt("WNX");
    q_hop.push_back({3'd3, rt("NX"), 1'b0}); t_hop.push_back("R8 pipelined a");
    @(negedge clk);
    hop_route_i = rt("XXX");
    q_hop.push_back({3'd4, AX, 1'b1}); t_hop.push_back("R9 pipelined b");
    @(negedge clk);
    hop_v = 0;
    repeat (3) @(negedge clk);

    chk(q_inj.size() == 0 && q_hop.size() == 0, "R8 all results seen",
        32'(q_inj.size() + q_hop.size()), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule